// File: doc/BRIEF.md
# Fractional-Period Timestamp Timer

This block keeps a 64-bit nanosecond timestamp that advances once per clock by a programmable period. The period is an integer nanosecond count plus a 24-bit binary fraction of a nanosecond. A small dither term trims the period below the resolution of the fraction, so clocks such as 1.6 ns or 10 ns can be followed without accumulating drift. The configuration fields are registered. A freeze input holds them so that later changes on the inputs have no effect.

In follower mode the timer compares its own time with an already-synchronized reference time. Only the bits at and above a selectable window position take part in the comparison. When those upper bits differ, the timer takes the reference's upper bits, zeroes everything below the window and restarts its fraction. When they agree, it keeps counting on its own clock. A valid flag shows when the timestamp can be trusted.

Top module: `frac_ts_timer`

## Requirements
- R1: After reset, `now_time` is 0 and `now_valid` is 0. The registered period is 1 ns, the fraction is 0, both trim counts are 0 and follower mode is off.
- R2: While `ctl_run` is 1, each clock adds the registered integer step to the time. It also adds the registered 24-bit fraction to a hidden fractional accumulator. A carry out of bit 23 of that accumulator adds one more nanosecond on the same clock.
- R3: While `ctl_run` and `ctl_clear` are both 0, `now_time` does not change.
- R4: `ctl_clear` = 1 clears the time, the fraction, the dither phase and the valid flag on the next clock, even when `ctl_run` is 1.
- R5: The configuration inputs are captured on every clock where `ctl_freeze` is 0 and take effect from the following clock. While `ctl_freeze` is 1 the captured values hold, and input changes have no effect.
- R6: A 4-bit dither phase counts the running cycles and wraps every 16. Let phase p be the current count. When p < up count, the fraction sum gets +1 LSB. When up count ≤ p < up + down count, it gets −1 LSB. Otherwise it is unchanged.
- R7: If the −1 LSB trim takes the fraction sum below zero, that cycle adds one nanosecond less than the integer step, and the fraction wraps to 0xFFFFFF.
- R8: In follower mode, when running and `(now_time ^ ref_time)` is nonzero at or above the window LSB, the next time is `ref_time` with the bits below the window zeroed. The fraction is also zeroed.
- R9: In follower mode, when the bits at and above the window LSB match, the timer advances normally as in R2.
- R10: The window LSB is 4 + 2 × `ctl_win_sel`, so codes 0, 1, 2 and 3 give bit positions 4, 6, 8 and 10.
- R11: `now_valid` is sticky until clear. Outside follower mode it rises after the first running clock. In follower mode it rises only after a running clock on which the window bits matched.
- R12: Large loaded values such as 0xdeadbeefcafef00d keep counting across all 64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_clear | input | 1 | Clear time, fraction, phase and valid |
| ctl_run | input | 1 | Advance the timer this clock |
| ctl_freeze | input | 1 | Hold the captured configuration |
| ctl_int_step | input | 8 | Integer nanoseconds per clock |
| ctl_frac_step | input | 24 | Fractional nanoseconds per clock, in units of 2^-24 ns |
| ctl_trim_up | input | 4 | Dither cycles per 16 that add one fraction LSB |
| ctl_trim_dn | input | 4 | Dither cycles per 16 that subtract one fraction LSB |
| ctl_follow | input | 1 | Enable follower (lock) mode |
| ctl_win_sel | input | 2 | Window LSB select code |
| ref_time | input | 64 | Synchronized reference time |
| now_time | output | 64 | Current time in nanoseconds |
| now_valid | output | 1 | Time is trustworthy |

## Verification
Whole-nanosecond steps check the integer path by itself. A 1.6 ns period over several spans separates correct carry handling from a dropped or extra carry. Dither patterns are chosen so that the result lands exactly on a carry boundary: a step of 1/16 ns with one subtract per 16 cycles, a near-full fraction with one add, and a zero fraction with subtracts that force a borrow. A wrong phase bound or a wrong sign then moves the time by a whole nanosecond. Follower tests load 0xdeadbeefcafef00d and then run free. They also move the reference inside and outside windows 10 and 4, which tells a matching comparison apart from one that loads on every clock or compares the wrong bits.

// File: rtl/ts_timer_pkg.sv
package ts_timer_pkg;

  typedef enum logic [1:0] {
    TRIM_NONE = 2'd0,
    TRIM_ADD  = 2'd1,
    TRIM_SUB  = 2'd2
  } trim_e;

  // Which trim applies at dither phase ph: adds first, then subtracts.
  function automatic trim_e trim_of(input logic [31:0] ph,
                                    input logic [31:0] up,
                                    input logic [31:0] dn);
    logic [32:0] sub_end;
    sub_end = {1'b0, up} + {1'b0, dn};
    if (ph < up) return TRIM_ADD;
    if ({1'b0, ph} < sub_end) return TRIM_SUB;
    return TRIM_NONE;
  endfunction

  // Bit position of the lowest compared bit for a window code.
  function automatic logic [31:0] win_lsb(input logic [31:0] sel,
                                          input logic [31:0] base,
                                          input logic [31:0] step);
    return base + sel * step;
  endfunction

endpackage

// File: rtl/ts_cfg_reg.sv
module ts_cfg_reg #(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 24,
  parameter int TRIM_W = 4,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freeze,
  input  logic [INT_W-1:0]  in_int,
  input  logic [FRAC_W-1:0] in_frac,
  input  logic [TRIM_W-1:0] in_up,
  input  logic [TRIM_W-1:0] in_dn,
  input  logic              in_follow,
  input  logic [SEL_W-1:0]  in_sel,
  output logic [INT_W-1:0]  cfg_int,
  output logic [FRAC_W-1:0] cfg_frac,
  output logic [TRIM_W-1:0] cfg_up,
  output logic [TRIM_W-1:0] cfg_dn,
  output logic              cfg_follow,
  output logic [SEL_W-1:0]  cfg_sel
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_int    <= INT_W'(1);
      cfg_frac   <= '0;
      cfg_up     <= '0;
      cfg_dn     <= '0;
      cfg_follow <= 1'b0;
      cfg_sel    <= '0;
    end else if (!freeze) begin
      cfg_int    <= in_int;
      cfg_frac   <= in_frac;
      cfg_up     <= in_up;
      cfg_dn     <= in_dn;
      cfg_follow <= in_follow;
      cfg_sel    <= in_sel;
    end
  end

endmodule

// File: rtl/ts_trim_seq.sv
module ts_trim_seq
  import ts_timer_pkg::*;
#(
  parameter int TRIM_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              advance,
  input  logic [TRIM_W-1:0] up,
  input  logic [TRIM_W-1:0] dn,
  output logic [TRIM_W-1:0] phase,
  output trim_e             kind
);

  // Phase wraps every 2**TRIM_W running cycles.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= '0;
    else if (clear)   phase <= '0;
    else if (advance) phase <= phase + 1'b1;
  end

  always_comb kind = trim_of(32'(phase), 32'(up), 32'(dn));

endmodule

// File: rtl/ts_frac_acc.sv
module ts_frac_acc
  import ts_timer_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int INT_W  = 8,
  parameter int FRAC_W = 24
) (
  input  logic [TIME_W-1:0] time_q,
  input  logic [FRAC_W-1:0] frac_q,
  input  logic [INT_W-1:0]  int_step,
  input  logic [FRAC_W-1:0] frac_step,
  input  trim_e             kind,
  output logic [TIME_W-1:0] time_adv,
  output logic [FRAC_W-1:0] frac_adv,
  output logic              carry_up,
  output logic              borrow
);

  localparam int SW = FRAC_W + 2;

  logic [SW-1:0] sum;

  always_comb begin
    sum = SW'(frac_q) + SW'(frac_step);
    case (kind)
      TRIM_ADD: sum = sum + SW'(1);
      TRIM_SUB: sum = sum - SW'(1);
      default:  ;
    endcase
  end

  assign carry_up = (sum[SW-1:FRAC_W] == 2'b01);
  assign borrow   = (sum[SW-1:FRAC_W] == 2'b11);
  assign frac_adv = sum[FRAC_W-1:0];
  assign time_adv = time_q + TIME_W'(int_step) + TIME_W'(carry_up) - TIME_W'(borrow);

endmodule

// File: rtl/ts_lock_cmp.sv
module ts_lock_cmp
  import ts_timer_pkg::*;
#(
  parameter int TIME_W   = 64,
  parameter int SEL_W    = 2,
  parameter int WIN_BASE = 4,
  parameter int WIN_STEP = 2
) (
  input  logic [TIME_W-1:0] local_time,
  input  logic [TIME_W-1:0] ref_time,
  input  logic [SEL_W-1:0]  sel,
  output logic [TIME_W-1:0] hi_mask,
  output logic              hi_match,
  output logic [TIME_W-1:0] load_value
);

  always_comb begin
    hi_mask    = {TIME_W{1'b1}} << win_lsb(32'(sel), 32'(WIN_BASE), 32'(WIN_STEP));
    hi_match   = (((local_time ^ ref_time) & hi_mask) == '0);
    load_value = ref_time & hi_mask;
  end

endmodule

// File: rtl/frac_ts_timer.sv
module frac_ts_timer
  import ts_timer_pkg::*;
#(
  parameter int TIME_W   = 64,
  parameter int INT_W    = 8,
  parameter int FRAC_W   = 24,
  parameter int TRIM_W   = 4,
  parameter int SEL_W    = 2,
  parameter int WIN_BASE = 4,
  parameter int WIN_STEP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_clear,
  input  logic              ctl_run,
  input  logic              ctl_freeze,
  input  logic [INT_W-1:0]  ctl_int_step,
  input  logic [FRAC_W-1:0] ctl_frac_step,
  input  logic [TRIM_W-1:0] ctl_trim_up,
  input  logic [TRIM_W-1:0] ctl_trim_dn,
  input  logic              ctl_follow,
  input  logic [SEL_W-1:0]  ctl_win_sel,
  input  logic [TIME_W-1:0] ref_time,
  output logic [TIME_W-1:0] now_time,
  output logic              now_valid
);

  // Captured configuration
  logic [INT_W-1:0]  cfg_int;
  logic [FRAC_W-1:0] cfg_frac;
  logic [TRIM_W-1:0] cfg_up;
  logic [TRIM_W-1:0] cfg_dn;
  logic              cfg_follow;
  logic [SEL_W-1:0]  cfg_sel;

  // State
  logic [TIME_W-1:0] time_q, time_d;
  logic [FRAC_W-1:0] frac_q, frac_d;
  logic              valid_q, valid_d;

  // Named internal events
  logic [TRIM_W-1:0] trim_phase;
  trim_e             trim_kind;
  logic [TIME_W-1:0] time_adv;
  logic [FRAC_W-1:0] frac_adv;
  logic              carry_up;
  logic              borrow;
  logic [TIME_W-1:0] hi_mask;
  logic              hi_match;
  logic [TIME_W-1:0] load_value;
  logic              lock_load;
  logic              free_step;

  ts_cfg_reg #(
    .INT_W(INT_W), .FRAC_W(FRAC_W), .TRIM_W(TRIM_W), .SEL_W(SEL_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .freeze(ctl_freeze),
    .in_int(ctl_int_step), .in_frac(ctl_frac_step),
    .in_up(ctl_trim_up), .in_dn(ctl_trim_dn),
    .in_follow(ctl_follow), .in_sel(ctl_win_sel),
    .cfg_int(cfg_int), .cfg_frac(cfg_frac),
    .cfg_up(cfg_up), .cfg_dn(cfg_dn),
    .cfg_follow(cfg_follow), .cfg_sel(cfg_sel)
  );

  ts_trim_seq #(.TRIM_W(TRIM_W)) u_trim (
    .clk(clk), .rst_n(rst_n), .clear(ctl_clear), .advance(ctl_run),
    .up(cfg_up), .dn(cfg_dn), .phase(trim_phase), .kind(trim_kind)
  );

  ts_frac_acc #(.TIME_W(TIME_W), .INT_W(INT_W), .FRAC_W(FRAC_W)) u_acc (
    .time_q(time_q), .frac_q(frac_q), .int_step(cfg_int), .frac_step(cfg_frac),
    .kind(trim_kind), .time_adv(time_adv), .frac_adv(frac_adv),
    .carry_up(carry_up), .borrow(borrow)
  );

  ts_lock_cmp #(
    .TIME_W(TIME_W), .SEL_W(SEL_W), .WIN_BASE(WIN_BASE), .WIN_STEP(WIN_STEP)
  ) u_lock (
    .local_time(time_q), .ref_time(ref_time), .sel(cfg_sel),
    .hi_mask(hi_mask), .hi_match(hi_match), .load_value(load_value)
  );

  assign lock_load = ctl_run && !ctl_clear && cfg_follow && !hi_match;
  assign free_step = ctl_run && !ctl_clear && !lock_load;

  always_comb begin
    time_d  = time_q;
    frac_d  = frac_q;
    valid_d = valid_q;
    if (ctl_clear) begin
      time_d  = '0;
      frac_d  = '0;
      valid_d = 1'b0;
    end else if (lock_load) begin
      time_d = load_value;
      frac_d = '0;
    end else if (free_step) begin
      time_d  = time_adv;
      frac_d  = frac_adv;
      valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q  <= '0;
      frac_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      time_q  <= time_d;
      frac_q  <= frac_d;
      valid_q <= valid_d;
    end
  end

  assign now_time  = time_q;
  assign now_valid = valid_q;

endmodule

// File: rtl/ts_timer_chk.sv
module ts_timer_chk #(
  parameter int TIME_W = 64,
  parameter int INT_W  = 8,
  parameter int FRAC_W = 24,
  parameter int TRIM_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_clear,
  input logic              ctl_run,
  input logic              ctl_freeze,
  input logic [TIME_W-1:0] ref_time,
  input logic [TIME_W-1:0] now_time,
  input logic              now_valid,
  input logic [INT_W-1:0]  cfg_int,
  input logic [FRAC_W-1:0] cfg_frac,
  input logic [TRIM_W-1:0] trim_phase,
  input logic              lock_load,
  input logic [TIME_W-1:0] hi_mask
);

  p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_clear |=> (now_time == '0 && !now_valid));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_clear && !ctl_run) |=> $stable(now_time));

  p_freeze_cfg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_freeze |=> ($stable(cfg_int) && $stable(cfg_frac)));

  p_phase_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_run && !ctl_clear) |=> (trim_phase == $past(trim_phase) + 1'b1));

  p_lock_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_load |=> ((((now_time ^ $past(ref_time)) & $past(hi_mask)) == '0)
                   && ((now_time & ~$past(hi_mask)) == '0)));

  p_valid_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (now_valid && !ctl_clear) |=> now_valid);

endmodule

bind frac_ts_timer ts_timer_chk #(
  .TIME_W(TIME_W), .INT_W(INT_W), .FRAC_W(FRAC_W), .TRIM_W(TRIM_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_clear(ctl_clear), .ctl_run(ctl_run),
  .ctl_freeze(ctl_freeze), .ref_time(ref_time), .now_time(now_time),
  .now_valid(now_valid), .cfg_int(cfg_int), .cfg_frac(cfg_frac),
  .trim_phase(trim_phase), .lock_load(lock_load), .hi_mask(hi_mask)
);

// File: tb/sim_frac_ts_timer.sv
`timescale 1ns/1ps
module sim_frac_ts_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_clear = 1'b0;
  logic        ctl_run = 1'b0;
  logic        ctl_freeze = 1'b0;
  logic [7:0]  ctl_int_step = 8'd1;
  logic [23:0] ctl_frac_step = '0;
  logic [3:0]  ctl_trim_up = '0;
  logic [3:0]  ctl_trim_dn = '0;
  logic        ctl_follow = 1'b0;
  logic [1:0]  ctl_win_sel = '0;
  logic [63:0] ref_time = '0;
  logic [63:0] now_time;
  logic        now_valid;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  frac_ts_timer u0 (
    .clk(clk), .rst_n(rst_n), .ctl_clear(ctl_clear), .ctl_run(ctl_run),
    .ctl_freeze(ctl_freeze), .ctl_int_step(ctl_int_step),
    .ctl_frac_step(ctl_frac_step), .ctl_trim_up(ctl_trim_up),
    .ctl_trim_dn(ctl_trim_dn), .ctl_follow(ctl_follow),
    .ctl_win_sel(ctl_win_sel), .ref_time(ref_time),
    .now_time(now_time), .now_valid(now_valid)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%016h expected=0x%016h", req, act, exp);
    end
  endtask

  // Expected time from the total value in 2^-24 ns units.
  function automatic longint exp_time(input longint i_s, input longint f_s,
                                      input longint up, input longint dn,
                                      input longint n);
    longint d = 0;
    for (longint k = 0; k < n; k++) begin
      longint p = k % 16;
      if (p < up) d = d + 1;
      else if (p < up + dn) d = d - 1;
    end
    return (n * ((i_s <<< 24) + f_s) + d) >>> 24;
  endfunction

  // Load configuration and clear in one clock; leaves timer stopped.
  task automatic setup(input logic [7:0] i_s, input logic [23:0] f_s,
                       input logic [3:0] up, input logic [3:0] dn,
                       input logic fol, input logic [1:0] sel);
    @(negedge clk);
    ctl_freeze = 1'b0; ctl_run = 1'b0; ctl_clear = 1'b1;
    ctl_int_step = i_s; ctl_frac_step = f_s;
    ctl_trim_up = up; ctl_trim_dn = dn;
    ctl_follow = fol; ctl_win_sel = sel;
    @(negedge clk);
    ctl_clear = 1'b0;
  endtask

  task automatic run_n(input int n);
    ctl_run = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    ctl_run = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 time after reset", now_time, 64'd0);
    chk("R1 valid after reset", {63'd0, now_valid}, 64'd0);
    run_n(3);
    chk("R1 default period 1ns", now_time, 64'd3);
  endtask

  task automatic t_integer;
    setup(8'd10, 24'd0, 4'd0, 4'd0, 1'b0, 2'd0);
    chk("R4 valid after clear", {63'd0, now_valid}, 64'd0);
    run_n(7);
    chk("R2 integer step 10", now_time, 64'd70);
    chk("R11 valid without follow", {63'd0, now_valid}, 64'd1);
    repeat (4) @(negedge clk);
    chk("R3 idle holds time", now_time, 64'd70);
  endtask

  task automatic t_fraction;
    setup(8'd1, 24'h999999, 4'd0, 4'd0, 1'b0, 2'd0);
    run_n(10);
    chk("R2 1.6ns after 10", now_time, 64'(exp_time(1, 24'h999999, 0, 0, 10)));
    run_n(15);
    chk("R2 1.6ns after 25", now_time, 64'(exp_time(1, 24'h999999, 0, 0, 25)));
  endtask

  task automatic t_trim;
    setup(8'd0, 24'h100000, 4'd0, 4'd1, 1'b0, 2'd0);
    run_n(16);
    chk("R6 one subtract per 16", now_time, 64'(exp_time(0, 24'h100000, 0, 1, 16)));
    run_n(1);
    chk("R6 phase wraps", now_time, 64'(exp_time(0, 24'h100000, 0, 1, 17)));
    setup(8'd0, 24'hFFFFFF, 4'd1, 4'd0, 1'b0, 2'd0);
    run_n(1);
    chk("R6 add tips carry", now_time, 64'd1);
  endtask

  task automatic t_borrow;
    setup(8'd2, 24'd0, 4'd0, 4'd4, 1'b0, 2'd0);
    run_n(1);
    chk("R7 borrow first cycle", now_time, 64'd1);
    run_n(3);
    chk("R7 borrow after 4", now_time, 64'(exp_time(2, 0, 0, 4, 4)));
  endtask

  task automatic t_freeze;
    setup(8'd1, 24'd0, 4'd0, 4'd0, 1'b0, 2'd0);
    @(negedge clk);
    ctl_int_step = 8'd3; ctl_run = 1'b1;
    @(negedge clk);
    @(negedge clk);
    ctl_run = 1'b0;
    chk("R5 config one cycle late", now_time, 64'd4);
    ctl_freeze = 1'b1; ctl_int_step = 8'd7;
    @(negedge clk);
    run_n(2);
    chk("R5 frozen config ignored", now_time, 64'd10);
    ctl_freeze = 1'b0;
    @(negedge clk);
    run_n(1);
    chk("R5 unfrozen config used", now_time, 64'd17);
  endtask

  task automatic t_clear;
    setup(8'd5, 24'd0, 4'd0, 4'd0, 1'b0, 2'd0);
    run_n(3);
    @(negedge clk);
    ctl_run = 1'b1; ctl_clear = 1'b1;
    @(negedge clk);
    ctl_run = 1'b0; ctl_clear = 1'b0;
    chk("R4 clear beats run", now_time, 64'd0);
    chk("R4 clear drops valid", {63'd0, now_valid}, 64'd0);
  endtask

  task automatic t_lock;
    ref_time = 64'hdeadbeefcafef00d;
    setup(8'd1, 24'd0, 4'd0, 4'd0, 1'b1, 2'd1);
    run_n(1);
    chk("R8 load upper bits", now_time, 64'hdeadbeefcafef000);
    chk("R11 no valid before match", {63'd0, now_valid}, 64'd0);
    run_n(1);
    chk("R9 match runs free", now_time, 64'hdeadbeefcafef001);
    chk("R11 valid after match", {63'd0, now_valid}, 64'd1);
    run_n(5);
    chk("R12 large value counts", now_time, 64'hdeadbeefcafef006);
  endtask

  task automatic t_window;
    ref_time = 64'h400;
    setup(8'd1, 24'd0, 4'd0, 4'd0, 1'b1, 2'd3);
    run_n(1);
    chk("R10 window 10 load", now_time, 64'h400);
    ref_time = 64'h7E8;
    run_n(3);
    chk("R10 window 10 match", now_time, 64'h403);
    ctl_win_sel = 2'd0;
    @(negedge clk);
    run_n(1);
    chk("R10 window 4 load", now_time, 64'h7E0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_integer();
    t_fraction();
    t_trim();
    t_borrow();
    t_freeze();
    t_clear();
    t_lock();
    t_window();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule